// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block manages a ring of receive buffer descriptors that sit in system memory. It serves one packet-receive DMA channel. A table address register holds the ring position. Its upper bits are a base aligned to 1 KiB. Its middle bits select one 8-byte descriptor out of 128. While the receiver is enabled, the block reads the control word of the current descriptor over a single-beat, word-wide memory port. If that descriptor is not yet handed over, the block keeps polling it. Once the descriptor is enabled, the block reads the buffer pointer and offers it to the payload data path.

When the data path reports a finished packet, it supplies the byte count and the error flags. The block then writes the status back into the descriptor's control word, with the enable bit cleared, which returns the descriptor to software. It then moves to the next descriptor. It goes back to the table base either at the 1 KiB end of the ring or early, at a descriptor whose wrap flag is set. A one-cycle interrupt pulse is raised when both the descriptor and the channel ask for it.

Top module: `rxdesc_ring`

## Requirements
- R1: After reset, `rx_active`, `buf_valid`, `mem_req` and `irq` are 0 and `tbl_addr` reads 0.
- R2: A write to the table address register takes bits 31:10 as base and bits 9:3 as descriptor selector, and bits 2:0 always read back 0. The write is ignored while `rx_active` is 1.
- R3: While `rx_en` is 1 and the block is idle, it reads the control word at `base + selector*8`. While `rx_en` is 0, no new read is started.
- R4: If bit 25 (enable) of the control word is 0, no buffer is offered. The same descriptor is read again until its enable bit reads 1.
- R5: For an enabled descriptor, the word at offset 4 is read and presented on `buf_addr` with `buf_valid` high until the packet completes or the receiver is disabled.
- R6: On `pkt_done`, the control word is written back as follows: bits 24:0 hold the byte count, bit 31 truncated, bit 30 data CRC error, bit 29 header CRC error, bit 28 error end-of-packet, bits 27 (interrupt request) and 26 (wrap) hold the values read at fetch, and bit 25 is 0.
- R7: When `pkt_len` exceeds `max_len`, bit 31 is set and the byte count written is `max_len`.
- R8: After each writeback without the wrap flag, the selector advances by one. From 127 it returns to 0, and the base stays unchanged.
- R9: After a writeback of a descriptor whose wrap flag (bit 26) is set, the selector becomes 0, even when the ring was started mid-table.
- R10: `irq` pulses high for exactly one cycle, the cycle after the writeback is accepted, only when bit 27 of that descriptor was 1 and `irq_en` is 1.
- R11: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`. A write never carries bit 25 set.
- R12: Dropping `rx_en` while a buffer is offered abandons that buffer without writing memory. A writeback already in progress completes before `rx_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table address register write strobe |
| cfg_wdata | input | 32 | Table address register write value |
| tbl_addr | output | 32 | Current table address (base and selector) |
| rx_en | input | 1 | Receiver enable |
| irq_en | input | 1 | Channel-level receive interrupt enable |
| max_len | input | 25 | Maximum accepted packet length in bytes |
| rx_active | output | 1 | Ring engine busy; table address may not be changed |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Memory read data |
| buf_valid | output | 1 | Receive buffer available to the data path |
| buf_addr | output | 32 | Receive buffer address |
| pkt_done | input | 1 | Packet complete pulse from the data path |
| pkt_len | input | 25 | Length of the completed packet |
| pkt_dcrc | input | 1 | Data CRC error on the completed packet |
| pkt_hcrc | input | 1 | Header CRC error on the completed packet |
| pkt_eep | input | 1 | Completed packet ended with an error end-of-packet |
| irq | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach is the natural wrap at the 1 KiB boundary. Normally it takes 127 packets before the selector moves from 127 back to 0. The stimulus avoids this by programming the selector to 126 while the receiver is stopped, so two packets cross the boundary. Those two packets run with a stalling memory acknowledge, so the held-request rule is exercised at the same time.

A second hard case is stopping the receiver in the middle of a writeback. The acknowledge is held low while `pkt_done` and the falling `rx_en` arrive together. This shows that `rx_active` stays high until the write lands.

// File: rtl/rxd_pkg.sv
// Shared constants and types for the receive descriptor ring controller.
// Assumes 8-byte descriptors; bit positions of the control word are fixed
// because software decodes them.
package rxd_pkg;
    localparam int DESC_BYTES = 8;
    localparam int CNT_W      = 25;
    localparam int W0_TRUNC   = 31;
    localparam int W0_DCRC    = 30;
    localparam int W0_HCRC    = 29;
    localparam int W0_EEP     = 28;
    localparam int W0_IE      = 27;
    localparam int W0_WRAP    = 26;
    localparam int W0_EN      = 25;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_PTR,
        ST_READY,
        ST_WRITEBACK
    } rxd_state_e;

    typedef struct packed {
        logic             trunc;
        logic             dcrc;
        logic             hcrc;
        logic             eep;
        logic [CNT_W-1:0] count;
    } rxd_status_t;
endpackage

// File: rtl/rxd_table_reg.sv
// Table address register: a 1 KiB-aligned base plus a descriptor selector.
// Assumes the caller only allows software writes while the engine is idle.
// The selector advances by one descriptor or clears on a wrap request;
// its natural overflow returns it to the table base.
module rxd_table_reg #(
    parameter int AW     = 32,
    parameter int SEL_W  = 7,
    parameter int DSH    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          cfg_allow,
    input  logic          adv,
    input  logic          adv_to_zero,
    output logic [AW-1:0] tbl_addr
);
    localparam int OFS_W = SEL_W + DSH;

    logic [AW-OFS_W-1:0] base_q;
    logic [SEL_W-1:0]    sel_q;

    // Hold base and selector; software write has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            sel_q  <= '0;
        end else if (cfg_we && cfg_allow) begin
            base_q <= cfg_wdata[AW-1:OFS_W];
            sel_q  <= cfg_wdata[OFS_W-1:DSH];
        end else if (adv) begin
            sel_q  <= adv_to_zero ? '0 : sel_q + 1'b1;
        end
    end

    assign tbl_addr = {base_q, sel_q, {DSH{1'b0}}};
endmodule

// File: rtl/rxd_status_pack.sv
// Builds the completion status from the data path's report.
// Clamps the byte count to the programmed maximum and flags truncation.
module rxd_status_pack
    import rxd_pkg::*;
(
    input  logic [CNT_W-1:0] pkt_len,
    input  logic [CNT_W-1:0] max_len,
    input  logic             pkt_dcrc,
    input  logic             pkt_hcrc,
    input  logic             pkt_eep,
    output rxd_status_t      status
);
    logic over;

    // Compare against the limit and select the count to report.
    always_comb begin
        over         = (pkt_len > max_len);
        status.trunc = over;
        status.dcrc  = pkt_dcrc;
        status.hcrc  = pkt_hcrc;
        status.eep   = pkt_eep;
        status.count = over ? max_len : pkt_len;
    end
endmodule

// File: rtl/rxd_engine.sv
// Descriptor engine: polls the current descriptor, fetches its buffer
// pointer, offers it to the data path, writes status back on completion
// and requests the selector advance. Assumes a single-beat memory port
// where read data is valid in the cycle mem_ack is high.
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          irq_en,
    input  logic [AW-1:0] desc_addr,
    input  rxd_status_t   status_in,
    input  logic          pkt_done,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          buf_valid,
    output logic [31:0]   buf_addr,
    output logic          rx_active,
    output logic          irq,
    output logic          adv,
    output logic          adv_to_zero
);
    localparam logic [AW-1:0] PTR_OFS = AW'(4);

    rxd_state_e  st_q, st_d;
    logic        ie_q, wrap_q, irq_q;
    logic [31:0] buf_q;
    rxd_status_t stat_q;
    logic        wb_done;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (rx_en) st_d = ST_FETCH_CTL;
            ST_FETCH_CTL: if (mem_ack) st_d = (rx_en && mem_rdata[W0_EN]) ? ST_FETCH_PTR : ST_IDLE;
            ST_FETCH_PTR: if (mem_ack) st_d = rx_en ? ST_READY : ST_IDLE;
            ST_READY: begin
                if (pkt_done)    st_d = ST_WRITEBACK;
                else if (!rx_en) st_d = ST_IDLE;
            end
            ST_WRITEBACK: if (mem_ack) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    assign wb_done = (st_q == ST_WRITEBACK) && mem_ack;

    // State and captured descriptor fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ie_q   <= 1'b0;
            wrap_q <= 1'b0;
            buf_q  <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= wb_done && ie_q && irq_en;
            if (st_q == ST_FETCH_CTL && mem_ack) begin
                ie_q   <= mem_rdata[W0_IE];
                wrap_q <= mem_rdata[W0_WRAP];
            end
            if (st_q == ST_FETCH_PTR && mem_ack) buf_q <= mem_rdata;
            if (st_q == ST_READY && pkt_done)    stat_q <= status_in;
        end
    end

    // Memory port and data-path outputs decoded from the state.
    always_comb begin
        mem_req   = (st_q == ST_FETCH_CTL) || (st_q == ST_FETCH_PTR) || (st_q == ST_WRITEBACK);
        mem_we    = (st_q == ST_WRITEBACK);
        mem_addr  = (st_q == ST_FETCH_PTR) ? (desc_addr | PTR_OFS) : desc_addr;
        mem_wdata = '0;
        if (st_q == ST_WRITEBACK) begin
            mem_wdata[W0_TRUNC]      = stat_q.trunc;
            mem_wdata[W0_DCRC]       = stat_q.dcrc;
            mem_wdata[W0_HCRC]       = stat_q.hcrc;
            mem_wdata[W0_EEP]        = stat_q.eep;
            mem_wdata[W0_IE]         = ie_q;
            mem_wdata[W0_WRAP]       = wrap_q;
            mem_wdata[W0_EN]         = 1'b0;
            mem_wdata[CNT_W-1:0]     = stat_q.count;
        end
    end

    assign buf_valid   = (st_q == ST_READY);
    assign buf_addr    = buf_q;
    assign rx_active   = (st_q != ST_IDLE);
    assign irq         = irq_q;
    assign adv         = wb_done;
    assign adv_to_zero = wrap_q;
endmodule

// File: rtl/rxdesc_ring.sv
// Top of the receive descriptor ring controller. Ties the table address
// register, the status packer and the descriptor engine together.
// Assumes TBL_BYTES is a power of two that is a multiple of the
// descriptor size.
module rxdesc_ring
    import rxd_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TBL_BYTES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-1:0]    tbl_addr,
    input  logic             rx_en,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] max_len,
    output logic             rx_active,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             buf_valid,
    output logic [31:0]      buf_addr,
    input  logic             pkt_done,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic             pkt_dcrc,
    input  logic             pkt_hcrc,
    input  logic             pkt_eep,
    output logic             irq
);
    localparam int DSH   = $clog2(DESC_BYTES);
    localparam int SEL_W = $clog2(TBL_BYTES / DESC_BYTES);

    logic        adv, adv_to_zero;
    rxd_status_t status;

    rxd_table_reg #(.AW(AW), .SEL_W(SEL_W), .DSH(DSH)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_allow  (!rx_active),
        .adv        (adv),
        .adv_to_zero(adv_to_zero),
        .tbl_addr   (tbl_addr)
    );

    rxd_status_pack u_stat (
        .pkt_len (pkt_len),
        .max_len (max_len),
        .pkt_dcrc(pkt_dcrc),
        .pkt_hcrc(pkt_hcrc),
        .pkt_eep (pkt_eep),
        .status  (status)
    );

    rxd_engine #(.AW(AW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .irq_en     (irq_en),
        .desc_addr  (tbl_addr),
        .status_in  (status),
        .pkt_done   (pkt_done),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .buf_valid  (buf_valid),
        .buf_addr   (buf_addr),
        .rx_active  (rx_active),
        .irq        (irq),
        .adv        (adv),
        .adv_to_zero(adv_to_zero)
    );
endmodule

// File: rtl/rxdesc_ring_chk.sv
// Protocol checker for the descriptor ring controller, bound to its top.
module rxdesc_ring_chk #(
    parameter int AW    = 32,
    parameter int OFS_W = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          rx_active,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          buf_valid,
    input logic [AW-1:0] tbl_addr,
    input logic          irq
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    wb_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[25]);

    // R3
    no_fetch_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_active && !rx_en) |=> !mem_req);

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    buf_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> rx_active);

    // R2
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> $stable(tbl_addr[AW-1:OFS_W]));
endmodule

bind rxdesc_ring rxdesc_ring_chk #(.AW(AW), .OFS_W($clog2(TBL_BYTES))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_active(rx_active),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .buf_valid(buf_valid),
    .tbl_addr (tbl_addr),
    .irq      (irq)
);

// File: tb/sim_rxdesc_ring.sv
`timescale 1ns/1ps
module sim_rxdesc_ring;
    localparam logic [31:0] BASE = 32'h0000_4400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] tbl_addr;
    logic        rx_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [24:0] max_len = 25'd2048;
    logic        rx_active, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        buf_valid;
    logic [31:0] buf_addr;
    logic        pkt_done = 1'b0;
    logic [24:0] pkt_len = '0;
    logic        pkt_dcrc = 1'b0, pkt_hcrc = 1'b0, pkt_eep = 1'b0;
    logic        irq;
    logic        ack_gate = 1'b1;
    logic        stall_mode = 1'b0;

    int n_chk = 0, n_err = 0, irq_cnt = 0, wb_cnt = 0;
    logic [31:0] mem [logic [31:0]];

    // Reference model state.
    int          m_st = 0;
    logic [21:0] m_base = '0;
    logic [6:0]  m_sel = '0;
    logic        m_ie = 1'b0, m_wr = 1'b0, m_irq = 1'b0;
    logic [31:0] m_buf = '0, m_wexp = '0;

    always #2.5 clk = ~clk;

    assign mem_ack = mem_req & ack_gate;

    rxdesc_ring u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tbl_addr(tbl_addr), .rx_en(rx_en), .irq_en(irq_en), .max_len(max_len),
        .rx_active(rx_active), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_addr(buf_addr),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .pkt_dcrc(pkt_dcrc),
        .pkt_hcrc(pkt_hcrc), .pkt_eep(pkt_eep), .irq(irq)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model step and memory write, both at the rising edge.
    always @(posedge clk) begin
        logic        ack;
        logic [31:0] a, w;
        logic        nirq;
        a    = {m_base, m_sel, 3'b000};
        nirq = 1'b0;
        ack  = (m_st == 1 || m_st == 2 || m_st == 4) && ack_gate;
        if (!rst_n) begin
            m_st = 0; m_base = '0; m_sel = '0; m_ie = 0; m_wr = 0; m_buf = '0;
        end else begin
            case (m_st)
                0: begin
                    if (cfg_we) begin m_base = cfg_wdata[31:10]; m_sel = cfg_wdata[9:3]; end
                    if (rx_en) m_st = 1;
                end
                1: if (ack) begin
                    w = rd(a);
                    if (!rx_en || !w[25]) m_st = 0;
                    else begin m_ie = w[27]; m_wr = w[26]; m_st = 2; end
                end
                2: if (ack) begin m_buf = rd(a | 32'h4); m_st = rx_en ? 3 : 0; end
                3: begin
                    if (pkt_done) begin
                        logic        tr;
                        logic [24:0] cnt;
                        tr = pkt_len > max_len;
                        cnt = tr ? max_len : pkt_len;
                        m_wexp = {tr, pkt_dcrc, pkt_hcrc, pkt_eep, m_ie, m_wr, 1'b0, cnt};
                        m_st = 4;
                    end else if (!rx_en) m_st = 0;
                end
                4: if (ack) begin
                    nirq = m_ie && irq_en;
                    m_sel = m_wr ? 7'd0 : m_sel + 7'd1;
                    m_st = 0;
                end
                default: m_st = 0;
            endcase
        end
        m_irq = rst_n && nirq;
        if (rst_n && mem_req && mem_we && mem_ack) begin
            mem[mem_addr] = mem_wdata;
            wb_cnt++;
        end
    end

    // Read data and optional stalling acknowledge, updated after the falling edge.
    always @(negedge clk) begin
        #1;
        if (stall_mode) ack_gate = ~ack_gate;
        mem_rdata = rd(mem_addr);
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        logic req_e;
        req_e = (m_st == 1 || m_st == 2 || m_st == 4);
        if (irq) irq_cnt++;
        check("R3 mem_req", {31'd0, mem_req}, {31'd0, req_e});
        check("R6 mem_we", {31'd0, mem_we}, {31'd0, m_st == 4});
        if (req_e)
            check("R3 mem_addr", mem_addr, {m_base, m_sel, 3'b000} | ((m_st == 2) ? 32'h4 : 32'h0));
        if (m_st == 4) check("R6 mem_wdata", mem_wdata, m_wexp);
        check("R5 buf_valid", {31'd0, buf_valid}, {31'd0, m_st == 3});
        if (m_st == 3) check("R5 buf_addr", buf_addr, m_buf);
        check("R12 rx_active", {31'd0, rx_active}, {31'd0, m_st != 0});
        check("R10 irq", {31'd0, irq}, {31'd0, m_irq});
        check("R8 tbl_addr", tbl_addr, {m_base, m_sel, 3'b000});
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_desc(input int sel, input logic ie, input logic wr, input logic en,
                            input logic [31:0] b);
        mem[BASE + sel * 8]     = {4'b0, ie, wr, en, 25'd0};
        mem[BASE + sel * 8 + 4] = b;
    endtask

    task automatic wait_buf;
        for (int i = 0; i < 400 && !buf_valid; i++) @(negedge clk);
    endtask

    task automatic run_pkt(input logic [24:0] len, input logic d, input logic h, input logic e);
        int start;
        wait_buf();
        start = wb_cnt;
        pkt_len = len; pkt_dcrc = d; pkt_hcrc = h; pkt_eep = e; pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
        for (int i = 0; i < 400 && wb_cnt == start; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        // R1: reset state
        check("R1 rx_active", {31'd0, rx_active}, 32'd0);
        check("R1 buf_valid", {31'd0, buf_valid}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tbl_addr", tbl_addr, 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R2: field split, low bits zero
        cfg_write(BASE | (32'd5 << 3) | 32'd7);
        check("R2 tbl_addr", tbl_addr, BASE + 32'h28);
        cyc(4);
        check("R3 idle no req", {31'd0, mem_req}, 32'd0);

        // R4: disabled descriptor polled without offering a buffer
        put_desc(5, 1'b1, 1'b0, 1'b0, 32'hA000_0500);
        put_desc(6, 1'b0, 1'b0, 1'b1, 32'hA000_0600);
        put_desc(7, 1'b1, 1'b1, 1'b1, 32'hA000_0700);
        irq_en = 1'b1;
        rx_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R4 no buf while disabled", {31'd0, buf_valid}, 32'd0);
        end
        put_desc(5, 1'b1, 1'b0, 1'b1, 32'hA000_0500);
        wait_buf();
        check("R5 buf_addr", buf_addr, 32'hA000_0500);

        // R6, R8, R10: clean packet with interrupt
        run_pkt(25'd100, 1'b0, 1'b0, 1'b0);
        check("R6 word0", rd(BASE + 32'h28), (32'd1 << 27) | 32'd100);
        check("R8 advance", tbl_addr, BASE + 32'h30);
        check("R10 irq count", irq_cnt, 1);

        // R7: truncated packet, no descriptor interrupt request
        run_pkt(25'd3000, 1'b1, 1'b0, 1'b0);
        check("R7 word0", rd(BASE + 32'h30), (32'd1 << 31) | (32'd1 << 30) | 32'd2048);
        check("R10 no irq without ie", irq_cnt, 1);

        // R9: wrap flag returns to base from mid-table; R10 channel gate
        irq_en = 1'b0;
        run_pkt(25'd7, 1'b0, 1'b1, 1'b1);
        check("R6 word0 flags", rd(BASE + 32'h38),
              (32'd1 << 29) | (32'd1 << 28) | (32'd1 << 27) | (32'd1 << 26) | 32'd7);
        check("R9 wrap to base", tbl_addr, BASE);
        check("R10 gated irq", irq_cnt, 1);

        // R8: natural wrap at the 1 KiB boundary, with stalled acknowledge (R11)
        rx_en = 1'b0;
        for (int i = 0; i < 50 && rx_active; i++) @(negedge clk);
        cfg_write(BASE | (32'd126 << 3));
        check("R2 mid-table start", tbl_addr, BASE + 32'h3F0);
        put_desc(126, 1'b1, 1'b0, 1'b1, 32'hB000_0126);
        put_desc(127, 1'b1, 1'b0, 1'b1, 32'hB000_0127);
        irq_en = 1'b1;
        stall_mode = 1'b1;
        rx_en = 1'b1;
        run_pkt(25'd64, 1'b0, 1'b0, 1'b0);
        run_pkt(25'd65, 1'b0, 1'b0, 1'b0);
        check("R8 boundary wrap", tbl_addr, BASE);
        check("R11 stalled word0", rd(BASE + 32'h3F8), (32'd1 << 27) | 32'd65);
        check("R10 irq count", irq_cnt, 3);
        stall_mode = 1'b0;
        ack_gate = 1'b1;

        // R2 ignored while active; R12 abandon offered buffer
        put_desc(0, 1'b0, 1'b0, 1'b1, 32'hC000_0000);
        wait_buf();
        cfg_write(32'h0000_8000);
        check("R2 write ignored", tbl_addr, BASE);
        rx_en = 1'b0;
        cyc(3);
        check("R12 stopped", {31'd0, rx_active}, 32'd0);
        check("R12 desc untouched", rd(BASE), 32'd1 << 25);

        // R12: writeback in flight completes before stopping
        rx_en = 1'b1;
        wait_buf();
        ack_gate = 1'b0;
        pkt_len = 25'd9; pkt_dcrc = 0; pkt_hcrc = 0; pkt_eep = 0;
        pkt_done = 1'b1; rx_en = 1'b0;
        @(negedge clk);
        pkt_done = 1'b0;
        cyc(3);
        check("R12 active during wb", {31'd0, rx_active}, 32'd1);
        ack_gate = 1'b1;
        cyc(3);
        check("R12 inactive after wb", {31'd0, rx_active}, 32'd0);
        check("R12 wb landed", rd(BASE), 32'd9);
        check("R8 after stop", tbl_addr, BASE + 32'h8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule